// File: doc/BRIEF.md
# Loop-Filtering Branch Trace Recorder

This block records change-of-flow activity from a processor into a circular trace memory. Each time the processor reports a taken branch, the recorder may write one line into an external trace RAM. The line holds the 24-bit address and a 2-bit code telling what kind of address it is: where the branch came from (source), where it went (destination), or an exception/interrupt vector.

Two modes share one line format. In normal mode every valid event is stored. In loop-filter mode a source address is dropped when it equals the last source address that was stored. This keeps a tight delay loop from filling the buffer with copies of one branch. Destination and vector lines are never filtered, because repeated destinations or vectors are often the symptom being hunted. Tracing starts on a rising edge of the arm input. That edge clears the write pointer, the line counter, the wrap flag and the remembered source address.

Top module: `cof_trace_rec`

## Requirements
- R1: During and after synchronous reset, with no event, `mem_we` is 0, `mem_addr` is 0, `line_cnt` is 0 and `wrapped` is 0.
- R2: A stored event shows `mem_we`=1 in the cycle after the event, with `mem_wdata[25:24]` = kind and `mem_wdata[23:0]` = address. The kind codes are source = 2'b10, destination = 2'b11 and vector = 2'b01.
- R3: An event with kind 2'b00, or one given while `arm` is 0, writes nothing and leaves `line_cnt` and `wrapped` unchanged.
- R4: In normal mode (`loop_mode`=0) every source event is stored, including back-to-back identical ones.
- R5: In loop-filter mode (`loop_mode`=1) a source event whose address equals the most recently stored source address is not written.
- R6: Destination and vector events are always stored, even when repeated. Storing one does not change the remembered source address.
- R7: A rising edge of `arm` resets the write pointer, `line_cnt` and `wrapped`, and forgets the remembered source. The first source stored after arming is therefore never filtered.
- R8: A suppressed event advances neither the write address nor `line_cnt`.
- R9: `mem_addr` rises by one per stored line and wraps from DEPTH-1 to 0. `wrapped` becomes 1 at the first wrap and stays 1 until re-armed.
- R10: `line_cnt` counts stored lines and saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Tracing enable; its rising edge restarts the trace |
| loop_mode | input | 1 | 0 = normal, 1 = loop filter |
| ev_valid | input | 1 | Change-of-flow event strobe |
| ev_kind | input | 2 | 10 source, 11 destination, 01 vector, 00 none |
| ev_addr | input | 24 | Event address |
| mem_we | output | 1 | Trace RAM write enable (registered) |
| mem_addr | output | $clog2(DEPTH) | Trace RAM line address (registered) |
| mem_wdata | output | 26 | Trace RAM line {kind, address} (registered) |
| line_cnt | output | CNT_W | Stored line count, saturating |
| wrapped | output | 1 | Buffer has wrapped at least once |

## Verification
Every result is due exactly one clock edge after its stimulus. An event applied before edge N appears on `mem_we`, `mem_addr`, `mem_wdata`, `line_cnt` and `wrapped` right after edge N. The bench applies stimulus on a falling edge and samples on the next falling edge, so each check lands half a cycle after the one register stage and away from any edge. Filtered and ignored events are checked the same way: `mem_we` must be low in that cycle, and the following stored line must carry the next consecutive address and count.

// File: rtl/cof_trace_pkg.sv
package cof_trace_pkg;
  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_VEC  = 2'b01,
    KIND_SRC  = 2'b10,
    KIND_DST  = 2'b11
  } cof_kind_e;

  typedef struct packed {
    cof_kind_e         kind;
    logic [ADDR_W-1:0] addr;
  } trace_line_t;

  localparam int LINE_W = $bits(trace_line_t);
endpackage

// File: rtl/cof_src_filter.sv
module cof_src_filter #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ev_fire,
  input  logic              ev_is_src,
  input  logic              loop_mode,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              keep
);
  logic [ADDR_W-1:0] last_q;
  logic              last_vld_q;
  logic              dup;

  // the arm edge forgets the previous source, so nothing matches in that cycle
  assign dup  = last_vld_q && !start && (ev_addr == last_q);
  assign keep = ev_fire && !(ev_is_src && loop_mode && dup);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_vld_q <= 1'b0;
      last_q     <= '0;
    end else if (keep && ev_is_src) begin
      last_vld_q <= 1'b1;
      last_q     <= ev_addr;
    end else if (start) begin
      last_vld_q <= 1'b0;
    end
  end

  AST_LAST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(keep && ev_is_src) && !start) |=> $stable(last_q) && $stable(last_vld_q)); // R6
  AST_NO_DUP_SRC: assert property (@(posedge clk) disable iff (rst)
    (keep && ev_is_src && loop_mode && !start && last_vld_q) |-> (ev_addr != last_q)); // R5
endmodule

// File: rtl/cof_wr_ctrl.sv
module cof_wr_ctrl #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             keep,
  output logic [AW-1:0]    wr_addr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_q
);
  localparam logic [AW-1:0]    LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};

  logic [AW-1:0]    ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_base, cnt_d;
  logic             wrap_base, wrap_d;

  always_comb begin
    wr_addr   = start ? '0 : ptr_q;
    cnt_base  = start ? '0 : cnt_q;
    wrap_base = start ? 1'b0 : wrap_q;
    ptr_d     = wr_addr;
    cnt_d     = cnt_base;
    wrap_d    = wrap_base;
    if (keep) begin
      if (wr_addr == LAST_SLOT) begin
        ptr_d  = '0;
        wrap_d = 1'b1;
      end else begin
        ptr_d  = wr_addr + 1'b1;
      end
      if (cnt_base != CNT_MAX) cnt_d = cnt_base + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  AST_HOLD_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    (!keep && !start) |=> $stable(ptr_q) && $stable(cnt_q)); // R8
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wrap_q && !start) |=> wrap_q); // R9
  AST_CNT_NOSHRINK: assert property (@(posedge clk) disable iff (rst)
    !start |=> cnt_q >= $past(cnt_q)); // R10
endmodule

// File: rtl/cof_trace_rec.sv
module cof_trace_rec
  import cof_trace_pkg::*;
#(
  parameter int  DEPTH = 64,
  parameter int  CNT_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              loop_mode,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  output logic [CNT_W-1:0]  line_cnt,
  output logic              wrapped
);
  logic        arm_q, start, fire, is_src, keep;
  logic [AW-1:0] wr_addr;
  trace_line_t line;

  assign start  = arm && !arm_q;
  assign fire   = ev_valid && arm && (ev_kind != KIND_NONE);
  assign is_src = (ev_kind == KIND_SRC);
  assign line   = '{kind: cof_kind_e'(ev_kind), addr: ev_addr};

  cof_src_filter #(.ADDR_W(ADDR_W)) u_filter (
    .clk(clk), .rst(rst), .start(start), .ev_fire(fire), .ev_is_src(is_src),
    .loop_mode(loop_mode), .ev_addr(ev_addr), .keep(keep)
  );

  cof_wr_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .start(start), .keep(keep),
    .wr_addr(wr_addr), .cnt_q(line_cnt), .wrap_q(wrapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q     <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      arm_q  <= arm;
      mem_we <= keep;
      if (keep) begin
        mem_addr  <= wr_addr;
        mem_wdata <= line;
      end
    end
  end

  AST_WE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(ev_valid) && $past(arm))); // R3
  AST_WDATA_KIND: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[LINE_W-1 -: 2] != 2'b00)); // R2
  AST_KEEP_NON_SRC: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && arm && (ev_kind == 2'b11 || ev_kind == 2'b01)) |=> mem_we); // R6
endmodule

// File: tb/cof_trace_rec_bench.sv
module cof_trace_rec_bench;
  localparam int DEPTH = 8;
  localparam int CNT_W = 5;
  localparam int AW    = $clog2(DEPTH);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst, arm, loop_mode, ev_valid;
  logic [1:0]  ev_kind;
  logic [23:0] ev_addr;
  logic        mem_we, wrapped;
  logic [AW-1:0]    mem_addr;
  logic [25:0]      mem_wdata;
  logic [CNT_W-1:0] line_cnt;

  int n_chk = 0, n_fail = 0;
  int m_ptr = 0, m_cnt = 0, m_wrap = 0, m_vld = 0;
  logic [23:0] m_last = '0;

  always #10 clk = ~clk;

  cof_trace_rec #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cof_trace_rec (
    .clk(clk), .rst(rst), .arm(arm), .loop_mode(loop_mode), .ev_valid(ev_valid),
    .ev_kind(ev_kind), .ev_addr(ev_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .line_cnt(line_cnt), .wrapped(wrapped)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one event, applied at a falling edge, checked at the next falling edge
  task automatic ev(input logic [1:0] k, input logic [23:0] a, input string req);
    bit store;
    int waddr;
    store = arm && (k != 2'b00) &&
            !(k == 2'b10 && loop_mode && m_vld != 0 && a == m_last);
    waddr = m_ptr;
    if (store) begin
      m_ptr = (m_ptr + 1) % DEPTH;
      if (m_ptr == 0) m_wrap = 1;
      if (m_cnt < CMAX) m_cnt++;
      if (k == 2'b10) begin m_last = a; m_vld = 1; end
    end
    ev_valid = 1'b1; ev_kind = k; ev_addr = a;
    @(negedge clk);
    ev_valid = 1'b0; ev_kind = 2'b00;
    check(req, "mem_we", int'(mem_we), int'(store));
    if (store) begin
      check(req, "mem_addr", int'(mem_addr), waddr);
      check(req, "mem_wdata", int'(mem_wdata), int'({k, a}));
    end
    check(req, "line_cnt", int'(line_cnt), m_cnt);
    check(req, "wrapped", int'(wrapped), m_wrap);
  endtask

  task automatic rearm();
    arm = 1'b0;
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    m_ptr = 0; m_cnt = 0; m_wrap = 0; m_vld = 0;
    check("R7", "line_cnt after arm", int'(line_cnt), 0);
    check("R7", "wrapped after arm", int'(wrapped), 0);
  endtask

  task automatic t_reset();
    check("R1", "mem_we", int'(mem_we), 0);
    check("R1", "mem_addr", int'(mem_addr), 0);
    check("R1", "line_cnt", int'(line_cnt), 0);
    check("R1", "wrapped", int'(wrapped), 0);
  endtask

  task automatic t_normal();
    loop_mode = 1'b0;
    rearm();
    ev(2'b10, 24'h001000, "R2");
    ev(2'b10, 24'h001000, "R4");   // identical source kept in normal mode
    ev(2'b11, 24'h002000, "R2");
    ev(2'b01, 24'hFFFF80, "R2");
  endtask

  task automatic t_loop();
    loop_mode = 1'b1;
    rearm();
    ev(2'b10, 24'h00A000, "R7");   // first source after arming
    ev(2'b10, 24'h00A000, "R5");   // duplicate dropped
    ev(2'b10, 24'h00A000, "R8");   // still dropped, nothing advances
    ev(2'b11, 24'h00B000, "R6");
    ev(2'b11, 24'h00B000, "R6");   // repeated destination kept
    ev(2'b01, 24'h000100, "R6");
    ev(2'b01, 24'h000100, "R6");   // repeated vector kept
    ev(2'b10, 24'h00A000, "R6");   // dst/vec did not refresh comparison: dropped
    ev(2'b10, 24'h00C000, "R5");
    ev(2'b10, 24'h00A000, "R5");
    rearm();
    ev(2'b10, 24'h00A000, "R7");   // comparison forgotten on re-arm
  endtask

  task automatic t_ignore();
    ev(2'b00, 24'h123456, "R3");
    arm = 1'b0;
    @(negedge clk);
    ev(2'b11, 24'h654321, "R3");
    ev(2'b10, 24'h111111, "R3");
  endtask

  task automatic t_wrap();
    loop_mode = 1'b1;
    rearm();
    for (int i = 0; i < DEPTH + 3; i++) ev(2'b10, 24'(i * 4), "R9");
  endtask

  task automatic t_sat();
    loop_mode = 1'b0;
    rearm();
    for (int i = 0; i < CMAX + 4; i++) ev(2'b11, 24'h00F000, "R10");
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; arm = 1'b0; loop_mode = 1'b0; ev_valid = 1'b0;
    ev_kind = 2'b00; ev_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_loop();
    t_ignore();
    t_wrap();
    t_sat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule